// File: doc/BRIEF.md
# Covert Bank Command Decoder

This block sits beside a paged flash ROM on the memory bus of an 8-bit host and listens for a command hidden in ordinary read traffic. The host never writes a control register. It reads the same magic low address byte several times in a row, then makes one more read whose address carries the new bank number and a write-enable flag in its bits. The decoder then loads a bank register, which drives the upper address lines of the flash. When the flag is set, it opens a window that lets exactly one following bus access through as a flash write.

The strobes and address are first passed through a small synchronizer. All tracking advances on the falling edge of the memory request strobe as seen in the clock domain, and the parameter bits are captured on that same edge. The bank register and the write-arm flag change only when the strobe is released at the end of the parameter access, so the access in progress keeps seeing the old bank. A debug counter shows how far the sequencer has progressed.

Top module: `bank_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset sets the bank to 0 and clears the write-arm flag, the flash write enable and the sequence counter (seq_cnt = 0).
- R2: Each read access (rd_n low, wr_n high) whose address bits 7..0 equal 0xFE adds one to seq_cnt, going 0, 1, 2, 3. Address bits 9..8 are not looked at while matching.
- R3: While fewer than three matches have been counted, a read at any other low byte, or any write, returns seq_cnt to 0. A later matching read counts from 1 again.
- R4: The access that directly follows the third match is the parameter. If it is a read with address bit 9 set, the new bank is address bits 4..0. This holds even when its low byte is 0xFE.
- R5: If the parameter access is a write, or has address bit 9 clear, the command is dropped. The bank does not change and seq_cnt returns to 0.
- R6: The bank changes only after the parameter access ends, when mreq_n rises. During any access, the bank output keeps its value from before that access.
- R7: Address bit 8 of an accepted parameter sets wr_armed when it is 1 and leaves it clear when it is 0.
- R8: While wr_armed is set, the next access is taken by the write window and does not count toward a match. If it is a write, flash_wr_en is high while that access lasts. When the access ends, wr_armed clears and seq_cnt is 0.
- R9: flash_wr_en is never high outside the window access, and it is low again once that access has ended.
- R10: seq_cnt reads 0 to 3 for the match count, 4 from parameter capture until the end of the parameter access, and 5 while the write window is armed or in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than the host bus |
| rst | input | 1 | Synchronous active-high reset, tied to host reset |
| mreq_n | input | 1 | Host memory request strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | ADDR_W (10) | Low host address bits 9..0 |
| bank | output | BANK_W (5) | Current flash bank, drives the upper flash address lines |
| wr_armed | output | 1 | Write window armed or in use |
| flash_wr_en | output | 1 | High during the single write allowed through the window |
| seq_cnt | output | CNT_W (3) | Debug view of sequencer progress |

## Verification
The bench targets the points where a careless sequencer goes wrong. A fourth read at 0xFE must be taken as the parameter, which yields bank 30, and not counted as a fourth match. Without that, a later command would be lost. A write, or a read of an unrelated address, in the middle of the match run must restart the count. If it did not, stray accesses would trigger false commands. Bit 9 clear, or a write, in the parameter slot must leave the bank alone. The bank must keep its old value while the parameter access is still active, or the current fetch would land in a different page. Finally, the write window must let exactly one access through and must not count that access as a match. Reset is applied both while a command is half-entered and while a window is armed.

// File: rtl/bank_cmd_pkg.sv
package bank_cmd_pkg;

  // Sequencer states of the command tracker
  typedef enum logic [2:0] {
    TRK_HUNT   = 3'd0,  // counting magic reads
    TRK_PARAM  = 3'd1,  // next access carries the parameter
    TRK_COMMIT = 3'd2,  // parameter captured, waiting for strobe release
    TRK_WINDOW = 3'd3,  // write window armed, waiting for next access
    TRK_DRAIN  = 3'd4   // window access in progress
  } trk_state_e;

  // One bus access event as seen after synchronization
  typedef struct packed {
    logic start;  // falling edge of memory request
    logic fin;    // rising edge of memory request
    logic is_rd;
    logic is_wr;
  } bus_evt_t;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
  import bank_cmd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output bus_evt_t          evt,
  output logic [ADDR_W-1:0] evt_addr
);

  localparam int BUS_W  = ADDR_W + 3;
  localparam int MREQ_B = BUS_W - 1;
  localparam int RD_B   = BUS_W - 2;
  localparam int WR_B   = BUS_W - 3;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {ADDR_W{1'b0}}};

  logic [BUS_W-1:0] chain [SYNC_STAGES];
  logic [BUS_W-1:0] bus_now;
  logic             mreq_prev;

  // Synchronizer chain for strobes and address together
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= BUS_IDLE;
      mreq_prev <= 1'b1;
    end else begin
      chain[0] <= {mreq_n, rd_n, wr_n, addr};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      mreq_prev <= chain[SYNC_STAGES-1][MREQ_B];
    end
  end

  assign bus_now = chain[SYNC_STAGES-1];

  always_comb begin
    evt.start = !bus_now[MREQ_B] && mreq_prev;
    evt.fin   = bus_now[MREQ_B] && !mreq_prev;
    evt.is_rd = !bus_now[RD_B];
    evt.is_wr = !bus_now[WR_B];
    evt_addr  = bus_now[ADDR_W-1:0];
  end

endmodule

// File: rtl/cmd_tracker.sv
module cmd_tracker
  import bank_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BANK_W    = 5,
  parameter int MATCH_LEN = 3,
  parameter int MAGIC_W   = 8,
  parameter logic [MAGIC_W-1:0] MAGIC = 8'hFE,
  parameter int WEN_BIT   = 8,
  parameter int KEY_BIT   = 9,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              commit,
  output logic [BANK_W-1:0] cap_bank,
  output logic              cap_wen,
  output logic              win_wr_start,
  output logic              win_close,
  output logic [CNT_W-1:0]  seq_cnt
);

  localparam logic [CNT_W-1:0] LAST_HIT  = CNT_W'(MATCH_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_PARAM = CNT_W'(MATCH_LEN);
  localparam logic [CNT_W-1:0] CNT_HELD  = CNT_W'(MATCH_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_WIN   = CNT_W'(MATCH_LEN + 2);

  trk_state_e        state, state_n;
  logic [CNT_W-1:0]  hits, hits_n;
  logic [BANK_W-1:0] par_bank, par_bank_n;
  logic              par_wen, par_wen_n;
  logic              clean_rd, magic_hit, key_hit;

  assign clean_rd  = evt.is_rd && !evt.is_wr;
  assign magic_hit = clean_rd && (evt_addr[MAGIC_W-1:0] == MAGIC);
  assign key_hit   = clean_rd && evt_addr[KEY_BIT];

  always_comb begin
    state_n    = state;
    hits_n     = hits;
    par_bank_n = par_bank;
    par_wen_n  = par_wen;
    unique case (state)
      TRK_HUNT: begin
        if (evt.start) begin
          if (!magic_hit) begin
            hits_n = '0;
          end else if (hits == LAST_HIT) begin
            hits_n  = '0;
            state_n = TRK_PARAM;
          end else begin
            hits_n = hits + 1'b1;
          end
        end
      end
      TRK_PARAM: begin
        if (evt.start) begin
          if (key_hit) begin
            par_bank_n = evt_addr[BANK_W-1:0];
            par_wen_n  = evt_addr[WEN_BIT];
            state_n    = TRK_COMMIT;
          end else begin
            state_n = TRK_HUNT;
          end
        end
      end
      TRK_COMMIT: begin
        if (evt.fin) state_n = par_wen ? TRK_WINDOW : TRK_HUNT;
      end
      TRK_WINDOW: begin
        if (evt.start) state_n = TRK_DRAIN;
      end
      TRK_DRAIN: begin
        if (evt.fin) state_n = TRK_HUNT;
      end
      default: begin
        state_n = TRK_HUNT;
        hits_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TRK_HUNT;
      hits     <= '0;
      par_bank <= '0;
      par_wen  <= 1'b0;
    end else begin
      state    <= state_n;
      hits     <= hits_n;
      par_bank <= par_bank_n;
      par_wen  <= par_wen_n;
    end
  end

  assign commit       = (state == TRK_COMMIT) && evt.fin;
  assign cap_bank     = par_bank;
  assign cap_wen      = par_wen;
  assign win_wr_start = (state == TRK_WINDOW) && evt.start && evt.is_wr;
  assign win_close    = (state == TRK_DRAIN) && evt.fin;

  always_comb begin
    unique case (state)
      TRK_HUNT:   seq_cnt = hits;
      TRK_PARAM:  seq_cnt = CNT_PARAM;
      TRK_COMMIT: seq_cnt = CNT_HELD;
      TRK_WINDOW: seq_cnt = CNT_WIN;
      TRK_DRAIN:  seq_cnt = CNT_WIN;
      default:    seq_cnt = '0;
    endcase
  end

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl #(
  parameter int BANK_W = 5,
  parameter logic [BANK_W-1:0] RESET_BANK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [BANK_W-1:0] cap_bank,
  input  logic              cap_wen,
  input  logic              win_wr_start,
  input  logic              win_close,
  output logic [BANK_W-1:0] bank,
  output logic              wr_armed,
  output logic              flash_wr_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank        <= RESET_BANK;
      wr_armed    <= 1'b0;
      flash_wr_en <= 1'b0;
    end else begin
      if (commit) begin
        bank     <= cap_bank;
        wr_armed <= cap_wen;
      end
      if (win_wr_start) flash_wr_en <= 1'b1;
      if (win_close) begin
        wr_armed    <= 1'b0;
        flash_wr_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bank_cmd_decoder.sv
module bank_cmd_decoder
  import bank_cmd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BANK_W      = 5,
  parameter int MATCH_LEN   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MAGIC_W     = 8,
  parameter logic [MAGIC_W-1:0] MAGIC = 8'hFE,
  parameter int WEN_BIT     = 8,
  parameter int KEY_BIT     = 9,
  localparam int CNT_W      = $clog2(MATCH_LEN + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              wr_armed,
  output logic              flash_wr_en,
  output logic [CNT_W-1:0]  seq_cnt
);

  bus_evt_t          evt;
  logic [ADDR_W-1:0] evt_addr;
  logic              commit, cap_wen, win_wr_start, win_close;
  logic [BANK_W-1:0] cap_bank;

  bus_sampler #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .mreq_n   (mreq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .evt      (evt),
    .evt_addr (evt_addr)
  );

  cmd_tracker #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .MATCH_LEN (MATCH_LEN),
    .MAGIC_W   (MAGIC_W),
    .MAGIC     (MAGIC),
    .WEN_BIT   (WEN_BIT),
    .KEY_BIT   (KEY_BIT),
    .CNT_W     (CNT_W)
  ) u_tracker (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .evt_addr     (evt_addr),
    .commit       (commit),
    .cap_bank     (cap_bank),
    .cap_wen      (cap_wen),
    .win_wr_start (win_wr_start),
    .win_close    (win_close),
    .seq_cnt      (seq_cnt)
  );

  bank_ctrl #(
    .BANK_W     (BANK_W),
    .RESET_BANK ('0)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .commit       (commit),
    .cap_bank     (cap_bank),
    .cap_wen      (cap_wen),
    .win_wr_start (win_wr_start),
    .win_close    (win_close),
    .bank         (bank),
    .wr_armed     (wr_armed),
    .flash_wr_en  (flash_wr_en)
  );

endmodule

// File: rtl/bank_cmd_decoder_chk.sv
module bank_cmd_decoder_chk #(
  parameter int MATCH_LEN = 3,
  parameter int BANK_W    = 5,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [BANK_W-1:0] bank,
  input logic              wr_armed,
  input logic              flash_wr_en,
  input logic [CNT_W-1:0]  seq_cnt
);

  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(MATCH_LEN);
  localparam logic [CNT_W-1:0] C_HELD = CNT_W'(MATCH_LEN + 1);
  localparam logic [CNT_W-1:0] C_WIN  = CNT_W'(MATCH_LEN + 2);

  // R1: reset leaves bank 0 and the window closed
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (bank == '0) && !wr_armed && !flash_wr_en);

  // R2: while hunting, the counter only steps up by one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(seq_cnt) && seq_cnt != '0 && seq_cnt <= C_LAST)
      |-> seq_cnt == $past(seq_cnt) + 1'b1);

  // R6: bank moves only out of the captured-parameter state
  p_bank_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bank)) |-> $past(seq_cnt) == C_HELD);

  // R7: an armed window is reported by the debug counter
  p_armed_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    wr_armed |-> seq_cnt == C_WIN);

  // R8: closing the window returns the sequencer to idle
  p_close_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(wr_armed)) |-> seq_cnt == '0);

  // R9: flash write only inside the armed window
  p_fwe_window_r9: assert property (@(posedge clk) disable iff (rst)
    flash_wr_en |-> wr_armed);

  // R10: counter stays within its encoding
  p_cnt_range_r10: assert property (@(posedge clk) disable iff (rst)
    seq_cnt <= C_WIN);

endmodule

bind bank_cmd_decoder bank_cmd_decoder_chk #(
  .MATCH_LEN (MATCH_LEN),
  .BANK_W    (BANK_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bank        (bank),
  .wr_armed    (wr_armed),
  .flash_wr_en (flash_wr_en),
  .seq_cnt     (seq_cnt)
);

// File: tb/bank_cmd_decoder_bench.sv
`timescale 1ns/1ps
module bank_cmd_decoder_bench;

  localparam real CLK_NS = 8.0;
  localparam int  HOLD   = 4;
  localparam int  NVEC   = 30;

  // {wr, addr[9:0], exp bank[4:0], exp armed, exp cnt[2:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 10'h0FE, 5'd0,  1'b0, 3'd1},
    {1'b0, 10'h0FE, 5'd0,  1'b0, 3'd2},
    {1'b0, 10'h0FE, 5'd0,  1'b0, 3'd3},
    {1'b0, 10'h215, 5'd21, 1'b0, 3'd0},
    {1'b0, 10'h1FE, 5'd21, 1'b0, 3'd1},
    {1'b0, 10'h010, 5'd21, 1'b0, 3'd0},
    {1'b0, 10'h0FE, 5'd21, 1'b0, 3'd1},
    {1'b1, 10'h0FE, 5'd21, 1'b0, 3'd0},
    {1'b0, 10'h2FE, 5'd21, 1'b0, 3'd1},
    {1'b0, 10'h2FE, 5'd21, 1'b0, 3'd2},
    {1'b0, 10'h2FE, 5'd21, 1'b0, 3'd3},
    {1'b0, 10'h007, 5'd21, 1'b0, 3'd0},
    {1'b0, 10'h0FE, 5'd21, 1'b0, 3'd1},
    {1'b0, 10'h0FE, 5'd21, 1'b0, 3'd2},
    {1'b0, 10'h0FE, 5'd21, 1'b0, 3'd3},
    {1'b0, 10'h309, 5'd9,  1'b1, 3'd5},
    {1'b1, 10'h123, 5'd9,  1'b0, 3'd0},
    {1'b0, 10'h0FE, 5'd9,  1'b0, 3'd1},
    {1'b0, 10'h0FE, 5'd9,  1'b0, 3'd2},
    {1'b0, 10'h0FE, 5'd9,  1'b0, 3'd3},
    {1'b0, 10'h3FF, 5'd31, 1'b1, 3'd5},
    {1'b0, 10'h0FE, 5'd31, 1'b0, 3'd0},
    {1'b0, 10'h0FE, 5'd31, 1'b0, 3'd1},
    {1'b0, 10'h0FE, 5'd31, 1'b0, 3'd2},
    {1'b0, 10'h0FE, 5'd31, 1'b0, 3'd3},
    {1'b0, 10'h2FE, 5'd30, 1'b0, 3'd0},
    {1'b0, 10'h0FE, 5'd30, 1'b0, 3'd1},
    {1'b0, 10'h0FE, 5'd30, 1'b0, 3'd2},
    {1'b0, 10'h0FE, 5'd30, 1'b0, 3'd3},
    {1'b1, 10'h215, 5'd30, 1'b0, 3'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [9:0] addr = '0;
  logic [4:0] bank;
  logic       wr_armed, flash_wr_en;
  logic [2:0] seq_cnt;

  logic [4:0] mid_bank;
  logic       mid_fwe;
  logic [2:0] mid_cnt;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bank_cmd_decoder u_bank_cmd_decoder (
    .clk         (clk),
    .rst         (rst),
    .mreq_n      (mreq_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .bank        (bank),
    .wr_armed    (wr_armed),
    .flash_wr_en (flash_wr_en),
    .seq_cnt     (seq_cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic w, input logic [9:0] a);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = w; wr_n = !w;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    mid_bank = bank; mid_fwe = flash_wr_en; mid_cnt = seq_cnt;
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic magic3();
    for (int k = 0; k < 3; k++) do_access(1'b0, 10'h0FE);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset bank", bank, 0);
    chk("R1 reset armed", wr_armed, 0);
    chk("R1 reset flash write", flash_wr_en, 0);
    chk("R1 reset count", seq_cnt, 0);

    // table walk
    begin
      logic [4:0] pb;
      logic       parm;
      pb = '0; parm = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
        logic [19:0] v;
        v = VEC[i];
        do_access(v[19], v[18:9]);
        chk("R6 bank held during access", mid_bank, pb);
        chk("R9 flash write only in window", mid_fwe, parm & v[19]);
        chk("R4 bank after access", bank, v[8:4]);
        chk("R7 armed after access", wr_armed, v[3]);
        chk("R2 count after access", seq_cnt, v[2:0]);
        chk("R9 flash write idle", flash_wr_en, 0);
        pb = v[8:4]; parm = v[3];
      end
    end

    // R3: breaks and restart
    do_reset();
    do_access(1'b0, 10'h0FE); do_access(1'b0, 10'h0FE);
    do_access(1'b0, 10'h0FD);
    chk("R3 mismatch clears count", seq_cnt, 0);
    do_access(1'b0, 10'h0FE);
    chk("R3 restart at one", seq_cnt, 1);
    do_access(1'b1, 10'h0FE);
    chk("R3 write clears count", seq_cnt, 0);

    // R5: rejected parameters
    magic3();
    do_access(1'b1, 10'h215);
    chk("R5 write parameter bank", bank, 0);
    chk("R5 write parameter count", seq_cnt, 0);
    magic3();
    do_access(1'b0, 10'h115);
    chk("R5 key bit clear bank", bank, 0);
    chk("R5 key bit clear count", seq_cnt, 0);

    // R10 and R6: parameter in flight
    magic3();
    do_access(1'b0, 10'h20A);
    chk("R10 count during parameter", mid_cnt, 4);
    chk("R6 old bank during parameter", mid_bank, 0);
    chk("R4 new bank", bank, 10);

    // R8: window consumes one access
    magic3();
    do_access(1'b0, 10'h303);
    chk("R7 armed", wr_armed, 1);
    chk("R10 window count", seq_cnt, 5);
    do_access(1'b1, 10'h055);
    chk("R8 flash write during window", mid_fwe, 1);
    chk("R8 armed cleared", wr_armed, 0);
    chk("R8 count idle", seq_cnt, 0);
    chk("R8 bank kept", bank, 3);
    magic3();
    do_access(1'b0, 10'h301);
    do_access(1'b0, 10'h0FE);
    chk("R8 window read not counted", seq_cnt, 0);
    chk("R8 window read disarms", wr_armed, 0);
    do_access(1'b1, 10'h055);
    chk("R9 write outside window", mid_fwe, 0);

    // R1: reset while armed and mid sequence
    magic3();
    do_access(1'b0, 10'h30C);
    chk("R7 armed before reset", wr_armed, 1);
    chk("R4 bank before reset", bank, 12);
    do_reset();
    chk("R1 bank after reset", bank, 0);
    chk("R1 armed after reset", wr_armed, 0);
    chk("R1 count after reset", seq_cnt, 0);
    do_access(1'b0, 10'h0FE); do_access(1'b0, 10'h0FE);
    do_reset();
    chk("R1 partial count cleared", seq_cnt, 0);
    do_access(1'b0, 10'h0FE);
    chk("R2 count after reset", seq_cnt, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule